// File: doc/BRIEF.md
# Receive volume gain stage

This block scales 13-bit two's complement receive samples by one of eight fixed gains before they go on to the output filter. The gain is picked by a 3-bit volume code that arrives together with each sample, so every sample may carry a different setting. The steps are 3 dB apart and run from +3 dB down to -18 dB.

When the receive path runs in companded mode, the volume code has no meaning. The stage then passes samples through at unity gain. A mute input forces the output sample to zero in either mode. Each result leaves one clock after its input strobe. It is rounded and clipped to the 13-bit range, and it stays on the output until the next strobe replaces it.

Top module: `rxvol_top`

## Requirements
- R1: Each cycle with `inValid` high is followed, one clock later, by exactly one cycle with `outValid` high. `outValid` is low in every other cycle.
- R2: In linear mode (`compandMode`=0) the multiplier, in units of 1/16384, is selected by the code as follows: 3'b000 gives 23143 (+3 dB), 3'b001 gives 16384 (0 dB), 3'b010 gives 11599, 3'b011 gives 8211, 3'b100 gives 5813, 3'b101 gives 4115, 3'b110 gives 2914, and 3'b111 gives 2063 (-18 dB).
- R3: The output is floor((sample*multiplier + 8192)/16384), clipped to the range -4096..4095. It never wraps.
- R4: Each sample uses only the code presented in its own strobe cycle. A code change takes effect on the very next sample, and nothing is carried over from earlier samples.
- R5: With `compandMode`=1 and no mute, the output equals the input sample for every value of `volCode`.
- R6: With `muteIn`=1 in a strobe cycle, the output for that sample is zero in both modes. It still comes with its `outValid` pulse.
- R7: In cycles after which no strobe was taken, `outSample` holds its previous value.
- R8: While reset (`rstN` low) is applied, `outValid` and `outSample` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample strobe |
| inSample | input | 13 | Receive sample, two's complement |
| volCode | input | 3 | Volume code for this sample |
| compandMode | input | 1 | 1 = companded path, gain fixed at unity |
| muteIn | input | 1 | 1 = force output sample to zero |
| outValid | output | 1 | Result strobe, one clock after `inValid` |
| outSample | output | 13 | Scaled, rounded, clipped sample |

## Verification
The assertions assume that `volCode`, `compandMode` and `muteIn` are only meaningful in strobe cycles and are sampled together with `inSample` at the same edge. The bench drives all inputs on the falling edge and keeps them steady through the following rising edge. The stimulus covers every code on positive and negative samples, both full-scale extremes at +3 dB, and back-to-back strobes with changing codes. It also includes gaps between strobes and mute in both modes, so each assumed input pattern is reached without any setup or hold hazard.

// File: rtl/rxvol_pkg.sv
package rxvol_pkg;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 14;
  localparam int CODE_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              mute;
    logic [CODE_W-1:0] gainSel;
  } volCtl_t;

  // multiplier per volume step, Q2.14
  function automatic logic signed [COEF_W-1:0] gainCoef(input logic [CODE_W-1:0] sel);
    case (sel)
      3'd0:    return 16'sd23143;
      3'd1:    return 16'sd16384;
      3'd2:    return 16'sd11599;
      3'd3:    return 16'sd8211;
      3'd4:    return 16'sd5813;
      3'd5:    return 16'sd4115;
      3'd6:    return 16'sd2914;
      default: return 16'sd2063;
    endcase
  endfunction
endpackage

// File: rtl/rxvol_ctrl.sv
module rxvol_ctrl
  import rxvol_pkg::*;
(
  input  logic              inValid,
  input  logic [CODE_W-1:0] volCode,
  input  logic              compandMode,
  input  logic              muteIn,
  output volCtl_t           ctl
);
  localparam logic [CODE_W-1:0] UNITY_CODE = CODE_W'(1);

  always_comb begin
    ctl.load    = inValid;
    ctl.mute    = muteIn;
    // companded path ignores the code and runs at 0 dB
    ctl.gainSel = compandMode ? UNITY_CODE : volCode;
  end
endmodule

// File: rtl/rxvol_datapath.sv
module rxvol_datapath
  import rxvol_pkg::*;
#(
  parameter int SAMPLE_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  volCtl_t             ctl,
  input  logic [SAMPLE_W-1:0] inSample,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam logic signed [PROD_W-1:0] ROUND_BIAS = PROD_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] LIM_HI = (PROD_W'(1) <<< (SAMPLE_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] LIM_LO = ~LIM_HI;
  localparam logic [SAMPLE_W-1:0] SAT_HI = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] SAT_LO = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;
  logic [SAMPLE_W-1:0]      satNext;

  always_comb begin
    prod    = $signed(inSample) * gainCoef(ctl.gainSel);
    rounded = (prod + ROUND_BIAS) >>> FRAC_W;
    if (ctl.mute)              satNext = '0;
    else if (rounded > LIM_HI) satNext = SAT_HI;
    else if (rounded < LIM_LO) satNext = SAT_LO;
    else                       satNext = rounded[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) outSample <= satNext;
    end
  end

  // R3: a non-negative sample never comes out negative (no wrap at +3 dB)
  assert_no_wrap_pos_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.mute && !inSample[SAMPLE_W-1]) |=> !outSample[SAMPLE_W-1]);
  // R3: a negative sample never comes out positive
  assert_no_wrap_neg_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.mute && inSample[SAMPLE_W-1]) |=>
      (outSample[SAMPLE_W-1] || outSample == '0));
  // R7: no strobe, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(outSample));
endmodule

// File: rtl/rxvol_top.sv
module rxvol_top
  import rxvol_pkg::*;
#(
  parameter int SAMPLE_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [CODE_W-1:0]   volCode,
  input  logic                compandMode,
  input  logic                muteIn,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);
  volCtl_t ctl;

  rxvol_ctrl u_ctrl (
    .inValid     (inValid),
    .volCode     (volCode),
    .compandMode (compandMode),
    .muteIn      (muteIn),
    .ctl         (ctl)
  );

  rxvol_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inSample  (inSample),
    .outValid  (outValid),
    .outSample (outSample)
  );

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_unity_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !compandMode && !muteIn && volCode == CODE_W'(1)) |=>
      outSample == $past(inSample));
  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && compandMode && !muteIn) |=> outSample == $past(inSample));
  assert_mute_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && muteIn) |=> (outValid && outSample == '0));
endmodule

// File: tb/sim_rxvol_top.sv
`timescale 1ns/1ps
module sim_rxvol_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [12:0] inSample = '0;
  logic [2:0]  volCode = '0;
  logic        compandMode = 1'b0;
  logic        muteIn = 1'b0;
  logic        outValid;
  logic [12:0] outSample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit seenOut = 1'b0;
  logic [12:0] lastOut = '0;
  int    expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  rxvol_top u0 (.*);

  function automatic int modelOut(int s, int code, bit comp, bit mute);
    longint c, p;
    if (mute) return 0;
    case (comp ? 1 : code)
      0: c = 23143; 1: c = 16384; 2: c = 11599; 3: c = 8211;
      4: c = 5813;  5: c = 4115;  6: c = 2914;  default: c = 2063;
    endcase
    p = (longint'(s) * c + 8192) >>> 14;
    if (p > 4095)  p = 4095;
    if (p < -4096) p = -4096;
    return int'(p);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic sendSample(int s, int code, bit comp, bit mute, string tag);
    @(negedge clk);
    inValid = 1'b1; inSample = s[12:0]; volCode = code[2:0];
    compandMode = comp; muteIn = mute;
    expQ.push_back(modelOut(s, code, comp, mute));
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; volCode = 3'd7 - volCode; muteIn = ~muteIn;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected outValid", 1, 0);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(int'($signed(outSample)) == e, t, int'($signed(outSample)), e);
        end
        lastOut = outSample;
        seenOut = 1'b1;
      end else if (seenOut) begin
        check(outSample == lastOut, "R7 hold",
              int'($signed(outSample)), int'($signed(lastOut)));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 reset outValid", int'(outValid), 0);
    check(outSample == '0, "R8 reset outSample", int'(outSample), 0);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    // R2: each code on positive and negative samples
    for (int k = 0; k < 8; k++) sendSample(1000, k, 1'b0, 1'b0, "R2 code pos");
    idle(1);
    for (int k = 0; k < 8; k++) sendSample(-2777, k, 1'b0, 1'b0, "R2 code neg");
    idle(3);
    // R3: clip at both extremes under +3 dB, and rounding of small values
    sendSample(4095, 0, 1'b0, 1'b0, "R3 clip high");
    sendSample(-4096, 0, 1'b0, 1'b0, "R3 clip low");
    sendSample(2900, 0, 1'b0, 1'b0, "R3 near limit");
    sendSample(-1, 7, 1'b0, 1'b0, "R3 round -1");
    sendSample(4, 7, 1'b0, 1'b0, "R3 round small");
    sendSample(-4096, 7, 1'b0, 1'b0, "R3 min at -18dB");
    idle(2);
    // R4: code changes every sample, same input value
    sendSample(3000, 7, 1'b0, 1'b0, "R4 per-sample");
    sendSample(3000, 0, 1'b0, 1'b0, "R4 per-sample");
    sendSample(3000, 3, 1'b0, 1'b0, "R4 per-sample");
    sendSample(3000, 1, 1'b0, 1'b0, "R4 per-sample");
    idle(1);
    // R5: companded path ignores code
    for (int k = 0; k < 8; k++) sendSample(4095 - k * 1100, k, 1'b1, 1'b0, "R5 bypass");
    sendSample(-4096, 0, 1'b1, 1'b0, "R5 bypass min");
    idle(2);
    // R6: mute in both modes, then recovery
    sendSample(2500, 0, 1'b0, 1'b1, "R6 mute linear");
    sendSample(-3000, 4, 1'b1, 1'b1, "R6 mute compand");
    sendSample(1234, 1, 1'b0, 1'b0, "R6 after mute");
    idle(4);
    // mixed sweep
    for (int i = 0; i < 200; i++)
      sendSample(((i * 389) % 8192) - 4096, (i * 5) % 8, i % 9 == 0, i % 13 == 0, "R2 sweep");
    idle(4);
    check(expQ.size() == 0, "R1 count", expQ.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule